// File: doc/BRIEF.md
# Low-Power Wakeup Decision Controller

This block decides the cycle in which a sleeping processor core resumes. When the core asks to enter a low-power state, it gives three things: the instruction style (wait-for-interrupt or wait-for-event), the depth (light or deep) and a request strobe. The controller then watches the wake sources that suit that entry. In a light state these are the interrupt lines, qualified by enable and priority, and the event-mode external lines. In a deep state they are the external reset, the watchdog reset, the enabled wake pins and the RTC event.

When a source qualifies, the controller emits a one-cycle wake pulse. With the pulse it says whether an interrupt is to be taken, or, for a deep exit, whether the core must go through a full restart. A send-event-on-pending setting changes how wait-for-event treats interrupts. In that setting any line whose pending bit newly rises wakes the core, including a disabled line. Only lines that are enabled and have enough priority are taken.

Top module: `lpw_wake_ctrl`

## Requirements
- R1: After reset, wakePulse, takeIrq and restartReq are 0 and the controller is in the run state.
- R2: In a light wait-for-interrupt state, a line that is pending, enabled and beats the mask wakes the core with takeIrq=1 and restartReq=0. A pending but disabled line does not wake it.
- R3: A line's priority beats the mask only when irqPrio (lower value is higher priority) is strictly below prioMask. A prioMask of 0 lets every priority through. An equal value does not beat the mask.
- R4: In wait-for-event with sevOnPend=0, only a pending, enabled line that beats the mask wakes the core from the interrupt side, and it is taken (takeIrq=1). A disabled line that becomes pending does not wake it.
- R5: In wait-for-event with sevOnPend=1, a 0-to-1 change of any pending bit wakes the core, including a disabled line. takeIrq is 1 only if some line is pending, enabled and beats the mask at that moment.
- R6: With sevOnPend=1, a pending bit that was already high when the core entered does not wake it.
- R7: An active extEvent bit wakes a wait-for-event state with takeIrq=0. extEvent has no effect in wait-for-interrupt.
- R8: In a deep state, extRstReq, wdogRstReq or rtcEvent wakes the core with restartReq=1 and takeIrq=0.
- R9: A deep state also wakes on a 0-to-1 change of a wakePin bit whose wakePinEn bit is 1. A pin that is disabled, or that stays high from before entry, does not wake it.
- R10: wakePulse is high for exactly one cycle, the cycle after the edge that samples the wake condition. The controller then runs and ignores every source until the next enterReq. A source active in the same cycle as enterReq is ignored.
- R11: A light state ignores the deep sources. A deep state ignores interrupts and extEvent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enterReq | input | 1 | Low-power entry request strobe |
| enterWfe | input | 1 | 1 = wait-for-event entry, 0 = wait-for-interrupt |
| enterDeep | input | 1 | 1 = deep (standby) depth, 0 = light |
| sevOnPend | input | 1 | Send-event-on-pending setting |
| irqPending | input | NUM_IRQ | Per-line pending bits |
| irqEnable | input | NUM_IRQ | Per-line enable bits |
| irqPrio | input | NUM_IRQ*PRIO_W | Per-line priority, line n at bits n*PRIO_W upward |
| prioMask | input | PRIO_W | Current priority mask, 0 = no masking |
| extEvent | input | NUM_EXT | Event-mode external lines |
| extRstReq | input | 1 | External reset request |
| wdogRstReq | input | 1 | Watchdog reset request |
| wakePin | input | NUM_PIN | Wake pin levels |
| wakePinEn | input | NUM_PIN | Wake pin enables |
| rtcEvent | input | 1 | RTC wake event |
| wakePulse | output | 1 | One-cycle wake pulse |
| takeIrq | output | 1 | Interrupt to be taken with this wake |
| restartReq | output | 1 | Full restart request with a deep wake |

## Verification
Two cases can coincide. The first is an entry request that arrives in the same cycle as a live wake source. The bench pulses enterReq while rtcEvent is high and lets rtcEvent drop before the next edge. It then expects no wake and proves that the core is asleep by waking it afterwards. The second is a wait-for-event wake where a disabled line rises together with, or apart from, a qualifying enabled line. The bench judges whether takeIrq follows only the qualifying line and not the cause of the wake.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LIGHT = 2'd1,
    ST_DEEP  = 2'd2
  } lpwState_e;

  // datapath -> control summary of the wake sources
  typedef struct packed {
    logic anyQual;     // some line pending, enabled, above mask
    logic anyNewPend;  // some pending bit rose this cycle
    logic anyExt;      // some event line active
    logic anyDeepSrc;  // some standby source active
  } lpwFlags_t;

  // control -> datapath strobes
  typedef struct packed {
    logic fire;
    logic take;
    logic restart;
  } lpwStrobe_t;

endpackage

// File: rtl/lpw_prio_gate.sv
module lpw_prio_gate #(
  parameter int PRIO_W = 4
) (
  input  logic              pending,
  input  logic              enable,
  input  logic [PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0] mask,
  output logic              qualified
);
  logic beatsMask;

  always_comb begin
    beatsMask = (mask == '0) || (prio < mask);
    qualified = pending && enable && beatsMask;
  end
endmodule

// File: rtl/lpw_datapath.sv
module lpw_datapath
  import lpw_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 4,
  parameter int NUM_EXT = 4,
  parameter int NUM_PIN = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IRQ-1:0]        irqPending,
  input  logic [NUM_IRQ-1:0]        irqEnable,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W-1:0]         prioMask,
  input  logic [NUM_EXT-1:0]        extEvent,
  input  logic                      extRstReq,
  input  logic                      wdogRstReq,
  input  logic [NUM_PIN-1:0]        wakePin,
  input  logic [NUM_PIN-1:0]        wakePinEn,
  input  logic                      rtcEvent,
  input  lpwStrobe_t                strobe,
  output lpwFlags_t                 flags,
  output logic                      wakePulse,
  output logic                      takeIrq,
  output logic                      restartReq
);
  logic [NUM_IRQ-1:0] pendPrev;
  logic [NUM_PIN-1:0] pinPrev;
  logic [NUM_IRQ-1:0] qualVec;
  logic [NUM_IRQ-1:0] newPend;
  logic [NUM_PIN-1:0] pinEdge;

  for (genvar gLine = 0; gLine < NUM_IRQ; gLine++) begin : g_line
    lpw_prio_gate #(.PRIO_W(PRIO_W)) i_gate (
      .pending   (irqPending[gLine]),
      .enable    (irqEnable[gLine]),
      .prio      (irqPrio[gLine*PRIO_W +: PRIO_W]),
      .mask      (prioMask),
      .qualified (qualVec[gLine])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPrev <= '0;
      pinPrev  <= '0;
    end else begin
      pendPrev <= irqPending;
      pinPrev  <= wakePin;
    end
  end

  always_comb begin
    newPend          = irqPending & ~pendPrev;
    pinEdge          = wakePin & ~pinPrev & wakePinEn;
    flags.anyQual    = |qualVec;
    flags.anyNewPend = |newPend;
    flags.anyExt     = |extEvent;
    flags.anyDeepSrc = extRstReq | wdogRstReq | rtcEvent | (|pinEdge);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakePulse  <= 1'b0;
      takeIrq    <= 1'b0;
      restartReq <= 1'b0;
    end else begin
      wakePulse  <= strobe.fire;
      takeIrq    <= strobe.take;
      restartReq <= strobe.restart;
    end
  end
endmodule

// File: rtl/lpw_control.sv
module lpw_control
  import lpw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enterReq,
  input  logic      enterWfe,
  input  logic      enterDeep,
  input  logic      sevOnPend,
  input  lpwFlags_t flags,
  output lpwStrobe_t strobe,
  output lpwState_e state,
  output logic      wfeMode
);
  lpwState_e stateNext;
  logic      wfeNext;
  logic      wakeCond;

  always_comb begin
    wakeCond = 1'b0;
    unique case (state)
      ST_LIGHT: begin
        if (!wfeMode)       wakeCond = flags.anyQual;
        else if (sevOnPend) wakeCond = flags.anyNewPend | flags.anyExt;
        else                wakeCond = flags.anyQual | flags.anyExt;
      end
      ST_DEEP:  wakeCond = flags.anyDeepSrc;
      default:  wakeCond = 1'b0;
    endcase
  end

  always_comb begin
    strobe.fire    = wakeCond;
    strobe.take    = wakeCond && (state == ST_LIGHT) && flags.anyQual;
    strobe.restart = wakeCond && (state == ST_DEEP);
  end

  always_comb begin
    stateNext = state;
    wfeNext   = wfeMode;
    if (state == ST_RUN) begin
      if (enterReq) begin
        stateNext = enterDeep ? ST_DEEP : ST_LIGHT;
        wfeNext   = enterWfe;
      end
    end else if (wakeCond) begin
      stateNext = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      wfeMode <= 1'b0;
    end else begin
      state   <= stateNext;
      wfeMode <= wfeNext;
    end
  end
endmodule

// File: rtl/lpw_wake_ctrl.sv
module lpw_wake_ctrl
  import lpw_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 4,
  parameter int NUM_EXT = 4,
  parameter int NUM_PIN = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enterReq,
  input  logic                      enterWfe,
  input  logic                      enterDeep,
  input  logic                      sevOnPend,
  input  logic [NUM_IRQ-1:0]        irqPending,
  input  logic [NUM_IRQ-1:0]        irqEnable,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W-1:0]         prioMask,
  input  logic [NUM_EXT-1:0]        extEvent,
  input  logic                      extRstReq,
  input  logic                      wdogRstReq,
  input  logic [NUM_PIN-1:0]        wakePin,
  input  logic [NUM_PIN-1:0]        wakePinEn,
  input  logic                      rtcEvent,
  output logic                      wakePulse,
  output logic                      takeIrq,
  output logic                      restartReq
);
  lpwFlags_t  flags;
  lpwStrobe_t strobe;
  lpwState_e  ctlState;
  logic       ctlWfe;

  lpw_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .enterReq  (enterReq),
    .enterWfe  (enterWfe),
    .enterDeep (enterDeep),
    .sevOnPend (sevOnPend),
    .flags     (flags),
    .strobe    (strobe),
    .state     (ctlState),
    .wfeMode   (ctlWfe)
  );

  lpw_datapath #(
    .NUM_IRQ (NUM_IRQ),
    .PRIO_W  (PRIO_W),
    .NUM_EXT (NUM_EXT),
    .NUM_PIN (NUM_PIN)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .irqPending (irqPending),
    .irqEnable  (irqEnable),
    .irqPrio    (irqPrio),
    .prioMask   (prioMask),
    .extEvent   (extEvent),
    .extRstReq  (extRstReq),
    .wdogRstReq (wdogRstReq),
    .wakePin    (wakePin),
    .wakePinEn  (wakePinEn),
    .rtcEvent   (rtcEvent),
    .strobe     (strobe),
    .flags      (flags),
    .wakePulse  (wakePulse),
    .takeIrq    (takeIrq),
    .restartReq (restartReq)
  );
endmodule

// File: rtl/lpw_wake_chk.sv
module lpw_wake_chk
  import lpw_pkg::*;
#(
  parameter int NUM_EXT = 4
) (
  input logic               clk,
  input logic               rstN,
  input lpwState_e          state,
  input logic               wfeMode,
  input logic [NUM_EXT-1:0] extEvent,
  input logic               extRstReq,
  input logic               wdogRstReq,
  input logic               rtcEvent,
  input logic               wakePulse,
  input logic               takeIrq,
  input logic               restartReq
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !wakePulse && !takeIrq && !restartReq);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  a_r10_from_sleep: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (state == ST_RUN) && ($past(state) != ST_RUN));

  a_r2_take_with_wake: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> wakePulse);

  a_r8_restart_deep: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |-> wakePulse && !takeIrq && ($past(state) == ST_DEEP));

  a_r8_deep_sources: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEEP && (extRstReq || wdogRstReq || rtcEvent)) |=> wakePulse && restartReq);

  a_r7_event_wakes: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LIGHT && wfeMode && (|extEvent)) |=> wakePulse && !restartReq);

  a_r11_light_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LIGHT) |=> !restartReq);
endmodule

bind lpw_wake_ctrl lpw_wake_chk #(.NUM_EXT(NUM_EXT)) i_wake_chk (
  .clk        (clk),
  .rstN       (rstN),
  .state      (ctlState),
  .wfeMode    (ctlWfe),
  .extEvent   (extEvent),
  .extRstReq  (extRstReq),
  .wdogRstReq (wdogRstReq),
  .rtcEvent   (rtcEvent),
  .wakePulse  (wakePulse),
  .takeIrq    (takeIrq),
  .restartReq (restartReq)
);

// File: tb/test_lpw_wake_ctrl.sv
module test_lpw_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ = 8;
  localparam int PRIO_W  = 4;
  localparam int NUM_EXT = 4;
  localparam int NUM_PIN = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enterReq = 1'b0, enterWfe = 1'b0, enterDeep = 1'b0, sevOnPend = 1'b0;
  logic [NUM_IRQ-1:0] irqPending = '0, irqEnable = '0;
  logic [NUM_IRQ*PRIO_W-1:0] irqPrio = '0;
  logic [PRIO_W-1:0] prioMask = '0;
  logic [NUM_EXT-1:0] extEvent = '0;
  logic extRstReq = 1'b0, wdogRstReq = 1'b0, rtcEvent = 1'b0;
  logic [NUM_PIN-1:0] wakePin = '0, wakePinEn = '0;
  logic wakePulse, takeIrq, restartReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpw_wake_ctrl #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .NUM_EXT(NUM_EXT), .NUM_PIN(NUM_PIN))
  i_lpw_wake_ctrl (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .enterWfe(enterWfe),
    .enterDeep(enterDeep), .sevOnPend(sevOnPend), .irqPending(irqPending),
    .irqEnable(irqEnable), .irqPrio(irqPrio), .prioMask(prioMask),
    .extEvent(extEvent), .extRstReq(extRstReq), .wdogRstReq(wdogRstReq),
    .wakePin(wakePin), .wakePinEn(wakePinEn), .rtcEvent(rtcEvent),
    .wakePulse(wakePulse), .takeIrq(takeIrq), .restartReq(restartReq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearSources();
    irqPending = '0; irqEnable = '0; irqPrio = '0; prioMask = '0;
    extEvent = '0; extRstReq = 1'b0; wdogRstReq = 1'b0; rtcEvent = 1'b0;
    wakePin = '0; wakePinEn = '0; sevOnPend = 1'b0;
  endtask

  task automatic setPrio(input int line, input int val);
    irqPrio[line*PRIO_W +: PRIO_W] = PRIO_W'(val);
  endtask

  // Call at a negedge; returns at the negedge after the entry edge.
  task automatic enter(input bit wfe, input bit deep);
    enterReq = 1'b1; enterWfe = wfe; enterDeep = deep;
    @(negedge clk);
    enterReq = 1'b0;
  endtask

  task automatic expectNone(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(wakePulse == 1'b0, req, "unexpected wake", int'(wakePulse), 0);
    end
  endtask

  task automatic expectWake(input bit take, input bit restart, input string req);
    @(negedge clk);
    check(wakePulse == 1'b1, req, "wakePulse", int'(wakePulse), 1);
    check(takeIrq == take, req, "takeIrq", int'(takeIrq), int'(take));
    check(restartReq == restart, req, "restartReq", int'(restartReq), int'(restart));
    @(negedge clk);
    check(wakePulse == 1'b0, "R10", "pulse width", int'(wakePulse), 0);
  endtask

  task automatic t_reset();
    check(wakePulse == 0 && takeIrq == 0 && restartReq == 0, "R1", "outputs at reset",
          int'({wakePulse, takeIrq, restartReq}), 0);
  endtask

  task automatic t_wfi();
    clearSources();
    enter(1'b0, 1'b0);
    irqPending[2] = 1'b1; setPrio(2, 1);
    expectNone(3, "R2");
    irqEnable[2] = 1'b1;
    expectWake(1'b1, 1'b0, "R2");
    clearSources();
  endtask

  task automatic t_prio();
    clearSources();
    prioMask = 4'd4;
    irqPending[1] = 1'b1; irqEnable[1] = 1'b1; setPrio(1, 4);
    enter(1'b0, 1'b0);
    expectNone(3, "R3");
    setPrio(1, 3);
    expectWake(1'b1, 1'b0, "R3");
    clearSources();
    prioMask = 4'd0;
    irqPending[5] = 1'b1; irqEnable[5] = 1'b1; setPrio(5, 15);
    enter(1'b0, 1'b0);
    expectWake(1'b1, 1'b0, "R3");
    clearSources();
  endtask

  task automatic t_wfe_sev0();
    clearSources();
    enter(1'b1, 1'b0);
    irqPending[0] = 1'b1;
    expectNone(3, "R4");
    irqPending[3] = 1'b1; irqEnable[3] = 1'b1;
    expectWake(1'b1, 1'b0, "R4");
    clearSources();
  endtask

  task automatic t_wfe_sev1();
    clearSources();
    sevOnPend = 1'b1;
    enter(1'b1, 1'b0);
    irqPending[6] = 1'b1;
    expectWake(1'b0, 1'b0, "R5");
    clearSources();
    sevOnPend = 1'b1;
    enter(1'b1, 1'b0);
    irqPending[6] = 1'b1; irqPending[4] = 1'b1; irqEnable[4] = 1'b1;
    expectWake(1'b1, 1'b0, "R5");
    clearSources();
  endtask

  task automatic t_sev1_level();
    clearSources();
    sevOnPend = 1'b1;
    irqPending[7] = 1'b1;
    @(negedge clk);
    enter(1'b1, 1'b0);
    expectNone(4, "R6");
    extEvent[2] = 1'b1;
    expectWake(1'b0, 1'b0, "R7");
    clearSources();
  endtask

  task automatic t_ext_wfi();
    clearSources();
    enter(1'b0, 1'b0);
    extEvent = '1;
    expectNone(3, "R7");
    extEvent = '0;
    irqPending[0] = 1'b1; irqEnable[0] = 1'b1;
    expectWake(1'b1, 1'b0, "R7");
    clearSources();
  endtask

  task automatic t_deep();
    enter(1'b0, 1'b1);
    irqPending = '1; irqEnable = '1; extEvent = '1;
    expectNone(3, "R11");
    clearSources();
    extRstReq = 1'b1;
    expectWake(1'b0, 1'b1, "R8");
    clearSources();
    enter(1'b1, 1'b1);
    wdogRstReq = 1'b1;
    expectWake(1'b0, 1'b1, "R8");
    clearSources();
    enter(1'b0, 1'b1);
    rtcEvent = 1'b1;
    expectWake(1'b0, 1'b1, "R8");
    // R10: source held after wake is ignored
    expectNone(3, "R10");
    clearSources();
  endtask

  task automatic t_pins();
    clearSources();
    wakePinEn[1] = 1'b1; wakePin[1] = 1'b1;
    @(negedge clk);
    enter(1'b0, 1'b1);
    expectNone(3, "R9");
    wakePin[0] = 1'b1;
    expectNone(3, "R9");
    wakePin[0] = 1'b0;
    @(negedge clk);
    wakePinEn[0] = 1'b1;
    wakePin[0] = 1'b1;
    expectWake(1'b0, 1'b1, "R9");
    clearSources();
  endtask

  task automatic t_light_ignores_deep();
    clearSources();
    enter(1'b1, 1'b0);
    rtcEvent = 1'b1; extRstReq = 1'b1; wdogRstReq = 1'b1;
    wakePinEn = '1; wakePin = '1;
    expectNone(3, "R11");
    clearSources();
    extEvent[0] = 1'b1;
    expectWake(1'b0, 1'b0, "R11");
    clearSources();
  endtask

  task automatic t_same_cycle_entry();
    clearSources();
    rtcEvent = 1'b1;
    enter(1'b0, 1'b1);
    rtcEvent = 1'b0;
    expectNone(3, "R10");
    wdogRstReq = 1'b1;
    expectWake(1'b0, 1'b1, "R10");
    clearSources();
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_wfi();
    t_prio();
    t_wfe_sev0();
    t_wfe_sev1();
    t_sev1_level();
    t_ext_wfi();
    t_deep();
    t_pins();
    t_light_ignores_deep();
    t_same_cycle_entry();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule